// File: doc/BRIEF.md
# Unsigned 64-bit Divide Execution Unit

This block is a multi-cycle execution unit for one integer instruction: the unsigned doubleword divide. On a start strobe it takes a 32-bit instruction word, the two 64-bit operand values already read from the register file, and the incoming overflow and summary-overflow status bits. It decodes the word and runs a bit-serial restoring divider. A fixed number of cycles later it returns the truncated quotient, the destination register index, the updated status bits and an optional 4-bit condition field.

The unit is not pipelined. It has a single operation in flight at a time, and its latency does not depend on the data. A zero divisor does not trap: the quotient is 0, and the status bits report the condition when overflow recording is enabled. The condition field compares the quotient with zero as a signed number, so a quotient with bit 63 set reports "less than".

Top module: `udiv64_exec`

## Requirements
- R1: A start while idle is accepted only when instr_i[31:26] equals 31 and instr_i[9:1] equals 457. Any other word raises illegal_o for exactly one cycle after the start edge. It produces no busy and no done.
- R2: dst_o equals instr_i[25:21] of the accepted word. The overflow-enable flag is instr_i[10] and the record flag is instr_i[0].
- R3: quot_o is the truncating unsigned division src_a_i / src_b_i over 64 bits.
- R4: When src_b_i is zero, quot_o is 0. The operation completes on the same schedule as any other.
- R5: With overflow-enable set, xer_ov_o is 1 exactly when the divisor is zero. xer_so_o is xer_so_i OR that new overflow value, so a set summary bit is never cleared.
- R6: With overflow-enable clear, xer_ov_o and xer_so_o equal xer_ov_i and xer_so_i as sampled at the start edge.
- R7: cr_we_o equals the record flag. cr_o is {LT, GT, EQ, SO}, where cr_o[3] is quotient bit 63, cr_o[1] is set for a zero quotient, cr_o[2] is set otherwise, and cr_o[0] equals xer_so_o.
- R8: done_o is a one-cycle pulse that appears exactly 70 clock edges after the accepting edge. busy_o is high from the accepting edge until done_o.
- R9: A start while busy_o is high is ignored. It does not raise illegal_o, does not change the result and does not produce an extra done_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start strobe, sampled when idle |
| instr_i | input | 32 | Instruction word |
| src_a_i | input | 64 | Dividend value |
| src_b_i | input | 64 | Divisor value |
| xer_ov_i | input | 1 | Incoming overflow bit |
| xer_so_i | input | 1 | Incoming summary-overflow bit |
| busy_o | output | 1 | Operation in flight |
| done_o | output | 1 | One-cycle completion pulse |
| illegal_o | output | 1 | Start word was not this instruction |
| quot_o | output | 64 | Quotient, valid from done_o |
| dst_o | output | 5 | Destination register index |
| xer_ov_o | output | 1 | Updated overflow bit |
| xer_so_o | output | 1 | Updated summary-overflow bit |
| cr_o | output | 4 | Condition field {LT, GT, EQ, SO} |
| cr_we_o | output | 1 | Condition field write enable |

## Verification
The hardest case to provoke from the ports is a start that arrives in the middle of a divide. To create it, the stimulus raises start partway through a running operation, once with a legal word and once with an illegal word carrying different operands. The scoreboard then confirms that only the first operation's result appears, that no extra done follows and that illegal_o stays low. Quotients with bit 63 set are produced on purpose with a divisor of one and a large dividend. This exercises the signed LT report on an unsigned value.

// File: rtl/udiv64_pkg.sv
package udiv64_pkg;

  localparam logic [5:0] PRIM_OP = 6'd31;
  localparam logic [8:0] EXT_OP  = 9'd457;

  typedef struct packed {
    logic       legal;
    logic [4:0] dst;
    logic       ovf_en;
    logic       rec;
  } dec_t;

  typedef struct packed {
    logic lt;
    logic gt;
    logic eq;
    logic so;
  } cond_t;

  // Next {ov, so} for the status bits.
  function automatic logic [1:0] xer_next(logic ovf_en, logic den_zero,
                                          logic ov_in, logic so_in);
    logic ov_new;
    ov_new = ovf_en ? den_zero : ov_in;
    return {ov_new, so_in | (ovf_en & den_zero)};
  endfunction

  // Signed compare against zero, from the sign bit and a nonzero flag.
  function automatic cond_t cond_of(logic sign, logic nonzero, logic so);
    cond_t c;
    c.lt = sign;
    c.gt = nonzero & ~sign;
    c.eq = ~nonzero;
    c.so = so;
    return c;
  endfunction

endpackage

// File: rtl/udiv64_decode.sv
module udiv64_decode
  import udiv64_pkg::*;
(
  input  logic [31:0] word_i,
  output dec_t        dec_o
);

  logic prim_hit;
  logic ext_hit;

  assign prim_hit = (word_i[31:26] == PRIM_OP);
  assign ext_hit  = (word_i[9:1] == EXT_OP);

  always_comb begin
    dec_o.legal  = prim_hit & ext_hit;
    dec_o.dst    = word_i[25:21];
    dec_o.ovf_en = word_i[10];
    dec_o.rec    = word_i[0];
  end

endmodule

// File: rtl/udiv64_core.sv
module udiv64_core #(
  parameter int unsigned W = 64
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] num_i,
  input  logic [W-1:0] den_i,
  input  logic         step_i,
  output logic [W-1:0] quot_o,
  output logic         den_zero_o
);

  logic [W-1:0] rem_q;
  logic [W-1:0] quo_q;
  logic [W-1:0] den_q;
  logic         zero_q;

  // One restoring step: shift in the next dividend bit, subtract if it fits.
  function automatic logic [2*W-1:0] div_step(logic [W-1:0] rem,
                                               logic [W-1:0] quo,
                                               logic [W-1:0] den);
    logic [W:0] trial;
    logic [W:0] diff;
    logic       take;
    trial = {rem, quo[W-1]};
    take  = (trial >= {1'b0, den});
    diff  = trial - {1'b0, den};
    return {(take ? diff[W-1:0] : trial[W-1:0]), quo[W-2:0], take};
  endfunction

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      quo_q  <= '0;
      den_q  <= '0;
      zero_q <= 1'b0;
    end else if (load_i) begin
      rem_q  <= '0;
      quo_q  <= num_i;
      den_q  <= den_i;
      zero_q <= (den_i == '0);
    end else if (step_i) begin
      {rem_q, quo_q} <= div_step(rem_q, quo_q, den_q);
    end
  end

  assign quot_o     = quo_q;
  assign den_zero_o = zero_q;

  // R3: the partial remainder stays below a nonzero divisor after every step
  a_r3_rem_below_den: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |=> (zero_q || (rem_q < den_q)));

endmodule

// File: rtl/udiv64_status.sv
module udiv64_status
  import udiv64_pkg::*;
#(
  parameter int unsigned W = 64
) (
  input  logic [W-1:0] quot_i,
  input  logic         den_zero_i,
  input  logic         ovf_en_i,
  input  logic         ov_i,
  input  logic         so_i,
  output logic [W-1:0] res_o,
  output logic         ov_o,
  output logic         so_o,
  output cond_t        cond_o
);

  logic [1:0] xer_n;

  assign res_o  = den_zero_i ? '0 : quot_i;
  assign xer_n  = xer_next(ovf_en_i, den_zero_i, ov_i, so_i);
  assign ov_o   = xer_n[1];
  assign so_o   = xer_n[0];
  assign cond_o = cond_of(res_o[W-1], |res_o, xer_n[0]);

endmodule

// File: rtl/udiv64_exec.sv
module udiv64_exec
  import udiv64_pkg::*;
#(
  parameter int unsigned W          = 64,
  parameter int unsigned SETUP_CYC  = 3,
  parameter int unsigned FINISH_CYC = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [31:0]  instr_i,
  input  logic [W-1:0] src_a_i,
  input  logic [W-1:0] src_b_i,
  input  logic         xer_ov_i,
  input  logic         xer_so_i,
  output logic         busy_o,
  output logic         done_o,
  output logic         illegal_o,
  output logic [W-1:0] quot_o,
  output logic [4:0]   dst_o,
  output logic         xer_ov_o,
  output logic         xer_so_o,
  output logic [3:0]   cr_o,
  output logic         cr_we_o
);

  localparam int unsigned LAT   = SETUP_CYC + W + FINISH_CYC;
  localparam int unsigned CNT_W = $clog2(LAT);
  localparam logic [CNT_W-1:0] STEP_FIRST = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] STEP_LAST  = CNT_W'(SETUP_CYC + W - 2);
  localparam logic [CNT_W-1:0] TICK_END   = CNT_W'(LAT - 1);

  dec_t             dec;
  logic             accept;
  logic             reject;
  logic             step;
  logic             finish;
  logic             busy_q;
  logic [CNT_W-1:0] tick_q;
  logic             ovf_en_q;
  logic             rec_q;
  logic [4:0]       dst_q;
  logic             ov_in_q;
  logic             so_in_q;
  logic [W-1:0]     core_quot;
  logic             den_zero;
  logic [W-1:0]     res;
  logic             ov_new;
  logic             so_new;
  cond_t            cond;

  udiv64_decode u_dec (
    .word_i (instr_i),
    .dec_o  (dec)
  );

  assign accept = start_i & ~busy_q & dec.legal;
  assign reject = start_i & ~busy_q & ~dec.legal;
  assign step   = busy_q & (tick_q >= STEP_FIRST) & (tick_q <= STEP_LAST);
  assign finish = busy_q & (tick_q == TICK_END);

  udiv64_core #(.W(W)) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (accept),
    .num_i      (src_a_i),
    .den_i      (src_b_i),
    .step_i     (step),
    .quot_o     (core_quot),
    .den_zero_o (den_zero)
  );

  udiv64_status #(.W(W)) u_stat (
    .quot_i     (core_quot),
    .den_zero_i (den_zero),
    .ovf_en_i   (ovf_en_q),
    .ov_i       (ov_in_q),
    .so_i       (so_in_q),
    .res_o      (res),
    .ov_o       (ov_new),
    .so_o       (so_new),
    .cond_o     (cond)
  );

  // Sequencer: busy flag and cycle counter
  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      tick_q <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      tick_q <= '0;
    end else if (finish) begin
      busy_q <= 1'b0;
      tick_q <= '0;
    end else if (busy_q) begin
      tick_q <= tick_q + 1'b1;
    end
  end

  // Captured instruction context
  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      ovf_en_q <= 1'b0;
      rec_q    <= 1'b0;
      dst_q    <= '0;
      ov_in_q  <= 1'b0;
      so_in_q  <= 1'b0;
    end else if (accept) begin
      ovf_en_q <= dec.ovf_en;
      rec_q    <= dec.rec;
      dst_q    <= dec.dst;
      ov_in_q  <= xer_ov_i;
      so_in_q  <= xer_so_i;
    end
  end

  // Result registers, loaded once at the end of the schedule
  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      done_o    <= 1'b0;
      illegal_o <= 1'b0;
      quot_o    <= '0;
      dst_o     <= '0;
      xer_ov_o  <= 1'b0;
      xer_so_o  <= 1'b0;
      cr_o      <= '0;
      cr_we_o   <= 1'b0;
    end else begin
      done_o    <= finish;
      illegal_o <= reject;
      if (finish) begin
        quot_o   <= res;
        dst_o    <= dst_q;
        xer_ov_o <= ov_new;
        xer_so_o <= so_new;
        cr_o     <= cond;
        cr_we_o  <= rec_q;
      end
    end
  end

  assign busy_o = busy_q;

  // R1: a rejected word leaves the unit idle
  a_r1_illegal_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (!busy_o && !done_o));

  // R8: done is a single-cycle pulse
  a_r8_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R8: busy only drops together with done
  a_r8_busy_ends_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  // R9: a start during an operation never reports illegal
  a_r9_busy_start_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && busy_o) |=> !illegal_o);

  // R4: zero divisor yields zero quotient
  a_r4_zero_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && den_zero) |-> (quot_o == '0));

  // R5: summary overflow is sticky
  a_r5_so_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && so_in_q) |-> xer_so_o);

  // R6: without overflow-enable the overflow bit passes through
  a_r6_ov_passthru: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !ovf_en_q) |-> (xer_ov_o == ov_in_q));

  // R7: exactly one of LT/GT/EQ and SO copies the status output
  a_r7_one_cond: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && cr_we_o) |-> ($countones(cr_o[3:1]) == 1 && cr_o[0] == xer_so_o));

endmodule

// File: tb/udiv64_exec_tb_top.sv
module udiv64_exec_tb_top;

  localparam int LAT = 70;

  typedef struct {
    logic [63:0] q;
    logic [4:0]  dst;
    logic        ov;
    logic        so;
    logic        oe;
    logic        we;
    logic [3:0]  cr;
    logic        dz;
    longint      acc;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] instr = '0;
  logic [63:0] src_a = '0;
  logic [63:0] src_b = '0;
  logic        ov_in = 1'b0;
  logic        so_in = 1'b0;
  logic        busy_o, done_o, illegal_o, xer_ov_o, xer_so_o, cr_we_o;
  logic [63:0] quot_o;
  logic [4:0]  dst_o;
  logic [3:0]  cr_o;

  int     errors = 0;
  int     checks = 0;
  longint cyc = 0;
  exp_t   sb[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  udiv64_exec dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .instr_i(instr),
    .src_a_i(src_a), .src_b_i(src_b), .xer_ov_i(ov_in), .xer_so_i(so_in),
    .busy_o(busy_o), .done_o(done_o), .illegal_o(illegal_o), .quot_o(quot_o),
    .dst_o(dst_o), .xer_ov_o(xer_ov_o), .xer_so_o(xer_so_o), .cr_o(cr_o),
    .cr_we_o(cr_we_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  function automatic logic [31:0] mk(logic [4:0] rt, logic oe, logic rc);
    return {6'd31, rt, 5'd3, 5'd4, oe, 9'd457, rc};
  endfunction

  // Reference model, written from the requirements
  function automatic exp_t model(logic [31:0] w, logic [63:0] a, logic [63:0] b,
                                 logic ovi, logic soi);
    exp_t e;
    logic lt, eq;
    e.dz  = (b == 64'd0);
    e.q   = e.dz ? 64'd0 : a / b;
    e.dst = w[25:21];
    e.oe  = w[10];
    e.we  = w[0];
    e.ov  = e.oe ? e.dz : ovi;
    e.so  = e.oe ? (soi || e.dz) : soi;
    lt    = ($signed(e.q) < 0);
    eq    = (e.q == 64'd0);
    e.cr  = {lt, !lt && !eq, eq, e.so};
    e.acc = 0;
    return e;
  endfunction

  // Driver: issue one legal operation and push its expectation
  task automatic issue(input logic [31:0] w, input logic [63:0] a,
                       input logic [63:0] b, input logic ovi, input logic soi);
    exp_t e;
    while (busy_o) @(negedge clk);
    instr = w; src_a = a; src_b = b; ov_in = ovi; so_in = soi; start = 1'b1;
    e = model(w, a, b, ovi, soi);
    @(posedge clk);
    #1 e.acc = cyc;
    sb.push_back(e);
    @(negedge clk);
    start = 1'b0;
  endtask

  // Monitor: pop and compare on each done
  always @(negedge clk) begin
    if (rst_n && done_o) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R9", "done without pending operation", 64'd1, 64'd0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(quot_o == e.q, e.dz ? "R4" : "R3", "quotient", quot_o, e.q);
        chk((cyc - e.acc) == LAT, "R8", "latency", 64'(cyc - e.acc), 64'(LAT));
        chk(dst_o == e.dst, "R2", "destination", 64'(dst_o), 64'(e.dst));
        chk({xer_ov_o, xer_so_o} == {e.ov, e.so}, e.oe ? "R5" : "R6",
            "ov/so", 64'({xer_ov_o, xer_so_o}), 64'({e.ov, e.so}));
        chk(cr_we_o == e.we, "R7", "cr write enable", 64'(cr_we_o), 64'(e.we));
        if (e.we) chk(cr_o == e.cr, "R7", "condition field", 64'(cr_o), 64'(e.cr));
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy_o == 1'b0, "R8", "reset busy", 64'(busy_o), 64'd0);
    chk(done_o == 1'b0, "R8", "reset done", 64'(done_o), 64'd0);
    chk(illegal_o == 1'b0, "R1", "reset illegal", 64'(illegal_o), 64'd0);

    // Directed corner cases
    issue(mk(5'd7, 1'b0, 1'b1), 64'd100, 64'd7, 1'b0, 1'b0);          // R3 basic
    issue(mk(5'd1, 1'b1, 1'b1), 64'h1234_5678_9abc_def0, 64'd0, 1'b0, 1'b0); // R4 R5
    issue(mk(5'd2, 1'b0, 1'b1), 64'd55, 64'd0, 1'b1, 1'b0);           // R4 R6
    issue(mk(5'd3, 1'b1, 1'b1), 64'd9, 64'd0, 1'b0, 1'b1);            // R5 sticky
    issue(mk(5'd4, 1'b1, 1'b1), 64'd9, 64'd3, 1'b1, 1'b1);            // R5 ov cleared, so kept
    issue(mk(5'd5, 1'b0, 1'b1), 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 1'b0, 1'b0); // R7 LT
    issue(mk(5'd6, 1'b1, 1'b1), 64'h8000_0000_0000_0000, 64'd1, 1'b0, 1'b0); // R7 LT
    issue(mk(5'd8, 1'b0, 1'b1), 64'd3, 64'd10, 1'b0, 1'b0);           // R7 EQ
    issue(mk(5'd9, 1'b0, 1'b0), 64'd77, 64'd11, 1'b1, 1'b1);          // R7 no write
    issue(mk(5'd31, 1'b1, 1'b1), 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b0);
    issue(mk(5'd10, 1'b0, 1'b1), 64'hFFFF_FFFF_FFFF_FFFF, 64'd2, 1'b0, 1'b0);

    // R1: illegal words
    for (int k = 0; k < 2; k++) begin
      while (busy_o) @(negedge clk);
      instr = (k == 0) ? {6'd31, 5'd1, 5'd2, 5'd3, 1'b0, 9'd456, 1'b0}
                       : {6'd30, 5'd1, 5'd2, 5'd3, 1'b0, 9'd457, 1'b0};
      start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      chk(illegal_o == 1'b1, "R1", "illegal flag", 64'(illegal_o), 64'd1);
      chk(busy_o == 1'b0, "R1", "illegal leaves idle", 64'(busy_o), 64'd0);
      @(negedge clk);
      chk(illegal_o == 1'b0, "R1", "illegal one cycle", 64'(illegal_o), 64'd0);
      repeat (LAT + 5) @(negedge clk);
    end

    // R9: starts during a running operation
    issue(mk(5'd12, 1'b1, 1'b1), 64'd1000, 64'd10, 1'b0, 1'b0);
    repeat (10) @(negedge clk);
    instr = {6'd0, 26'd5}; src_a = 64'd1; src_b = 64'd0; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    chk(illegal_o == 1'b0, "R9", "illegal while busy", 64'(illegal_o), 64'd0);
    chk(busy_o == 1'b1, "R9", "still busy", 64'(busy_o), 64'd1);
    repeat (10) @(negedge clk);
    instr = mk(5'd20, 1'b1, 1'b1); src_a = 64'd5; src_b = 64'd0; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    chk(busy_o == 1'b1, "R9", "legal start while busy", 64'(busy_o), 64'd1);

    // Random operands, including small divisors and top-bit quotients
    for (int i = 0; i < 24; i++) begin
      logic [63:0] a, b;
      a = {$urandom, $urandom};
      b = {$urandom, $urandom} >> ($urandom % 64);
      if (i % 6 == 5) b = 64'd1;
      issue(mk(5'($urandom), 1'($urandom), 1'($urandom)), a, b,
            1'($urandom), 1'($urandom));
    end

    while (sb.size() != 0) @(negedge clk);
    repeat (LAT + 5) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule